// File: doc/BRIEF.md
# SPI Word-to-Byte Data Buffer Pair

This block sits between a 32-bit register port and the byte-serial shift engine of an SPI controller. It holds two 32-byte rings: one fed by software with whole 32-bit words and drained by the shifter one byte at a time, and one fed by the shifter one byte at a time and drained by software with whole words. Transfers longer than 32 bytes are not meant to go through these buffers.

Each direction has its own two ordering controls. The byte-order control picks which end of a 32-bit word is first on the serial side. The bit-order control picks whether bit 7 or bit 0 of each byte is first on the wire. These four controls arrive as a 4-bit field. The field is the upper nibble of the controller's command word, bits 12 to 15, with the same bit order. On the shifter side a byte is always presented, and taken in, with its first wire bit in bit 7. The block applies the bit reversal, so the shifter only ever shifts bit 7 first.

An N-byte transfer uses ceil(N/4) word accesses. Bytes of the last word that the transfer does not need are left alone on transmit. On receive they read as zero. Overflow and underflow are kept as sticky flags. A software reset input empties both rings and clears the flags.

Top module: `spi_byte_fifo_pair`

## Requirements
- R1: After reset both levels are 0, `tx_byte_valid` is 0, `reg_rdata` is 0 and both sticky flags are 0.
- R2: A write strobe with `reg_addr` = 0x10 adds 4 bytes to the transmit ring, and `tx_level` grows by 4 on the next clock. A write to any other offset leaves `tx_level` unchanged.
- R3: Transmit byte order is set by `order_ctl[3]` (command bit 15). When it is clear, `reg_wdata[7:0]` leaves first and `reg_wdata[31:24]` leaves last. When it is set, the order is reversed.
- R4: Transmit bit order is set by `order_ctl[0]` (command bit 12). When it is set, `tx_byte` is the stored byte unchanged, so bit 7 is sent first. When it is clear, `tx_byte` is the stored byte bit-reversed.
- R5: A transmit write while fewer than 4 bytes are free is dropped. `tx_level` and the queued data stay as they were, and `tx_ovf_flag` becomes 1 and stays 1.
- R6: Receive bit order is set by `order_ctl[1]` (command bit 13). When it is set, `rx_byte` is stored unchanged. When it is clear, it is stored bit-reversed.
- R7: Receive byte order is set by `order_ctl[2]` (command bit 14). When it is clear, the first byte received lands in `reg_rdata[7:0]`. When it is set, it lands in `reg_rdata[31:24]`.
- R8: A read strobe with `reg_addr` = 0x14 removes min(level, 4) bytes from the receive ring. `reg_rdata` shows the word one clock after the strobe, and the lanes with no byte behind them are zero.
- R9: A receive read while the ring is empty returns 0 and sets `rx_unf_flag`, which stays 1.
- R10: A received byte that arrives while 32 bytes are held is dropped, and `rx_level` stays at 32.
- R11: `sw_rst` empties both rings, clears both flags and clears `reg_rdata`, all on the next clock.
- R12: `tx_byte_valid` is 1 exactly when `tx_level` is non-zero. A `tx_byte_take` while the transmit ring is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Software reset: empties both rings and clears the flags |
| order_ctl | input | 4 | {tx byte swap, rx byte swap, rx MSB first, tx MSB first} (command bits 15..12) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Word from the last receive read |
| tx_byte_valid | output | 1 | Transmit ring holds at least one byte |
| tx_byte_take | input | 1 | Shifter consumes `tx_byte` |
| tx_byte | output | 8 | Next transmit byte, first wire bit in bit 7 |
| rx_byte_valid | input | 1 | Shifter delivers `rx_byte` |
| rx_byte | input | 8 | Received byte, first wire bit in bit 7 |
| tx_level | output | 6 | Bytes held in the transmit ring |
| rx_level | output | 6 | Bytes held in the receive ring |
| tx_ovf_flag | output | 1 | Sticky: a transmit write was dropped |
| rx_unf_flag | output | 1 | Sticky: a read found the receive ring empty |

## Verification
`tx_byte` and `tx_byte_valid` follow the head of the transmit ring with no register in between. The bench therefore samples them on the falling edge just before it raises `tx_byte_take`. Levels, flags and `reg_rdata` are each one register away from their strobe. Every stimulus task raises its strobe on a falling edge and drops it on the next falling edge, and the checks read these outputs only after that second edge, so exactly one rising edge lies between the strobe and the sample. The ordering table runs all four bit-order and byte-order combinations in both directions. Directed tests follow for fill and drain to the 32-byte limit, partial final words, empty reads and the software reset.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // Positions inside the 4-bit ordering field (command bits 12..15).
  localparam int TX_MSB_IDX  = 0;
  localparam int RX_MSB_IDX  = 1;
  localparam int RX_SWAP_IDX = 2;
  localparam int TX_SWAP_IDX = 3;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/lane_order.sv
// Passes a word of byte lanes straight through, or mirrors the lane order.
module lane_order #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic          swap,
  input  logic [DW-1:0] in_word,
  output logic [DW-1:0] out_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign out_word[g*8 +: 8] = swap ? in_word[(LANES-1-g)*8 +: 8]
                                     : in_word[g*8 +: 8];
  end

endmodule

// File: rtl/byte_ring.sv
// Circular byte store. It takes up to PUSH_W bytes and releases up to POP_W
// bytes per clock. Lane 0 of push_data and peek_data is the oldest byte.
// DEPTH must be a power of two. The caller keeps push within the free space
// and pop within the level.
module byte_ring #(
  parameter int DEPTH  = 32,
  parameter int PUSH_W = 4,
  parameter int POP_W  = 1,
  localparam int PW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int UW  = $clog2(PUSH_W + 1),
  localparam int OW  = $clog2(POP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [UW-1:0]     push_cnt,
  input  logic [PUSH_W*8-1:0] push_data,
  input  logic [OW-1:0]     pop_cnt,
  output logic [POP_W*8-1:0]  peek_data,
  output logic [CW-1:0]     level
);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d;

  always_comb begin
    wr_d  = wr_q + PW'(push_cnt);
    rd_d  = rd_q + PW'(pop_cnt);
    lvl_d = lvl_q + CW'(push_cnt) - CW'(pop_cnt);
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  // Storage has no reset: the pointers and level alone say what is valid.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_W; i++) begin
      if (!flush && (i < int'(push_cnt)))
        mem_q[wr_q + PW'(i)] <= push_data[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < POP_W; g++) begin : g_peek
    assign peek_data[g*8 +: 8] = mem_q[rd_q + PW'(g)];
  end

  assign level = lvl_q;

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));

  // R5
  push_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (CW'(push_cnt) <= CW'(DEPTH) - lvl_q));

  // R12
  pop_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (CW'(pop_cnt) <= lvl_q));

endmodule

// File: rtl/spi_byte_fifo_pair.sv
module spi_byte_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int             DEPTH   = 32,
  parameter int             LANES   = 4,
  parameter int             AW      = 8,
  parameter logic [AW-1:0]  TX_ADDR = 8'h10,
  parameter logic [AW-1:0]  RX_ADDR = 8'h14,
  localparam int DW = LANES * 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic [3:0]    order_ctl,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_byte_valid,
  input  logic          tx_byte_take,
  output logic [7:0]    tx_byte,
  input  logic          rx_byte_valid,
  input  logic [7:0]    rx_byte,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          tx_ovf_flag,
  output logic          rx_unf_flag
);

  logic tx_msb, rx_msb, tx_swap, rx_swap;
  assign tx_msb  = order_ctl[TX_MSB_IDX];
  assign rx_msb  = order_ctl[RX_MSB_IDX];
  assign tx_swap = order_ctl[TX_SWAP_IDX];
  assign rx_swap = order_ctl[RX_SWAP_IDX];

  // ---------------- transmit direction ----------------
  logic          tx_wr_hit, tx_accept;
  logic [CW-1:0] tx_lvl, tx_free;
  logic [NW-1:0] tx_push_cnt;
  logic          tx_pop_cnt;
  logic [DW-1:0] tx_ordered;
  logic [7:0]    tx_peek;

  lane_order #(.LANES(LANES)) u_tx_order (
    .swap     (tx_swap),
    .in_word  (reg_wdata),
    .out_word (tx_ordered)
  );

  always_comb begin
    tx_wr_hit   = reg_wr && (reg_addr == TX_ADDR);
    tx_free     = CW'(DEPTH) - tx_lvl;
    tx_accept   = tx_wr_hit && !sw_rst && (tx_free >= CW'(LANES));
    tx_push_cnt = tx_accept ? NW'(LANES) : '0;
    tx_pop_cnt  = tx_byte_take && (tx_lvl != '0) && !sw_rst;
  end

  byte_ring #(.DEPTH(DEPTH), .PUSH_W(LANES), .POP_W(1)) u_tx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (sw_rst),
    .push_cnt  (tx_push_cnt),
    .push_data (tx_ordered),
    .pop_cnt   (tx_pop_cnt),
    .peek_data (tx_peek),
    .level     (tx_lvl)
  );

  assign tx_byte       = tx_msb ? tx_peek : rev8(tx_peek);
  assign tx_byte_valid = (tx_lvl != '0);
  assign tx_level      = tx_lvl;

  // ---------------- receive direction ----------------
  logic          rx_push_ok, rx_rd_hit;
  logic [CW-1:0] rx_lvl;
  logic [NW-1:0] rx_avail, rx_pop_cnt;
  logic [7:0]    rx_stored;
  logic [DW-1:0] rx_peek, rx_masked, rx_word;

  always_comb begin
    rx_push_ok = rx_byte_valid && !sw_rst && (rx_lvl != CW'(DEPTH));
    rx_stored  = rx_msb ? rx_byte : rev8(rx_byte);
    rx_rd_hit  = reg_rd && (reg_addr == RX_ADDR);
    rx_avail   = (rx_lvl >= CW'(LANES)) ? NW'(LANES) : NW'(rx_lvl);
    rx_pop_cnt = (rx_rd_hit && !sw_rst) ? rx_avail : '0;
    for (int i = 0; i < LANES; i++)
      rx_masked[i*8 +: 8] = (i < int'(rx_avail)) ? rx_peek[i*8 +: 8] : 8'h00;
  end

  byte_ring #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(LANES)) u_rx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (sw_rst),
    .push_cnt  (rx_push_ok),
    .push_data (rx_stored),
    .pop_cnt   (rx_pop_cnt),
    .peek_data (rx_peek),
    .level     (rx_lvl)
  );

  lane_order #(.LANES(LANES)) u_rx_order (
    .swap     (rx_swap),
    .in_word  (rx_masked),
    .out_word (rx_word)
  );

  assign rx_level = rx_lvl;

  // ---------------- read data and sticky flags ----------------
  logic [DW-1:0] rdata_q, rdata_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;

  always_comb begin
    rdata_d = rdata_q;
    ovf_d   = ovf_q | (tx_wr_hit && !tx_accept);
    unf_d   = unf_q | (rx_rd_hit && (rx_lvl == '0));
    if (rx_rd_hit) rdata_d = rx_word;
    if (sw_rst) begin
      rdata_d = '0;
      ovf_d   = 1'b0;
      unf_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign reg_rdata   = rdata_q;
  assign tx_ovf_flag = ovf_q;
  assign rx_unf_flag = unf_q;

  // R2
  tx_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_accept && !tx_pop_cnt) |=> (tx_lvl == $past(tx_lvl) + CW'(LANES)));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_flag && !sw_rst) |=> tx_ovf_flag);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_unf_flag && !sw_rst) |=> rx_unf_flag);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (tx_lvl == '0 && rx_lvl == '0 && reg_rdata == '0));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_hit && !sw_rst && rx_lvl == '0) |=> (reg_rdata == '0 && rx_unf_flag));

  // R12
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_byte_valid && tx_byte_take && !reg_wr) |=> (tx_lvl == '0));

endmodule

// File: tb/tb_spi_byte_fifo_pair.sv
module tb_spi_byte_fifo_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_rst;
  logic [3:0]  order_ctl;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tx_byte_valid, tx_byte_take;
  logic [7:0]  tx_byte;
  logic        rx_byte_valid;
  logic [7:0]  rx_byte;
  logic [5:0]  tx_level, rx_level;
  logic        tx_ovf_flag, rx_unf_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_fifo_pair dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .order_ctl(order_ctl),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_byte_valid(tx_byte_valid), .tx_byte_take(tx_byte_take), .tx_byte(tx_byte),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_ovf_flag(tx_ovf_flag), .rx_unf_flag(rx_unf_flag)
  );

  // Row: {msb_first, swap, tx word, expected tx stream (first byte in [31:24]),
  //       rx stream (first byte in [31:24]), expected read word}
  localparam logic [129:0] VEC [4] = '{
    {1'b1, 1'b0, 32'h12345601, 32'h01563412, 32'h01563412, 32'h12345601},
    {1'b1, 1'b1, 32'h12345601, 32'h12345601, 32'h01563412, 32'h01563412},
    {1'b0, 1'b0, 32'h12345601, 32'h806A2C48, 32'h01563412, 32'h482C6A80},
    {1'b0, 1'b1, 32'h12345601, 32'h482C6A80, 32'h01563412, 32'h806A2C48}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_word(input logic [7:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_byte_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_byte_valid = 1'b0;
  endtask

  task automatic take_tx(output logic [7:0] b);
    @(negedge clk); b = tx_byte; tx_byte_take = 1'b1;
    @(negedge clk); tx_byte_take = 1'b0;
  endtask

  task automatic pulse_sw_rst();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] acc;
    rst_n = 1'b0; sw_rst = 1'b0; order_ctl = 4'b0011;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_byte_take = 1'b0; rx_byte_valid = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 tx_byte_valid", 32'(tx_byte_valid), 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 flags", {30'b0, tx_ovf_flag, rx_unf_flag}, 0);

    // Ordering table: R3, R4 on transmit; R6, R7 on receive
    for (int v = 0; v < 4; v++) begin
      logic msb, swp;
      msb = VEC[v][129];
      swp = VEC[v][128];
      order_ctl = {swp, swp, msb, msb};
      wr_word(8'h10, VEC[v][127:96]);
      chk("R2 tx level after word", 32'(tx_level), 4);
      acc = '0;
      for (int k = 0; k < 4; k++) begin
        take_tx(b);
        acc = {acc[23:0], b};
      end
      chk("R3 R4 tx byte stream", acc, VEC[v][95:64]);
      for (int k = 0; k < 4; k++) push_rx(VEC[v][63-8*k -: 8]);
      chk("R6 rx level", 32'(rx_level), 4);
      rd_word(8'h14);
      chk("R6 R7 rx word", reg_rdata, VEC[v][31:0]);
      chk("R8 rx level after read", 32'(rx_level), 0);
    end

    order_ctl = 4'b0011;

    // R2: other offset ignored
    wr_word(8'h18, 32'hDEADBEEF);
    chk("R2 foreign offset", 32'(tx_level), 0);
    chk("R12 valid when empty", 32'(tx_byte_valid), 0);

    // R12: take on empty ignored
    take_tx(b);
    chk("R12 take on empty", 32'(tx_level), 0);

    // R5: fill to 32 then overflow
    for (int k = 0; k < 8; k++) wr_word(8'h10, 32'h03020100 + 32'(k) * 32'h04040404);
    chk("R5 full level", 32'(tx_level), 32);
    chk("R5 no ovf yet", 32'(tx_ovf_flag), 0);
    wr_word(8'h10, 32'hFFFFFFFF);
    chk("R5 dropped write level", 32'(tx_level), 32);
    chk("R5 ovf set", 32'(tx_ovf_flag), 1);
    for (int k = 0; k < 32; k++) begin
      take_tx(b);
      if (k == 0 || k == 31) chk("R5 drained byte", 32'(b), 32'(k));
    end
    chk("R12 drained valid", 32'(tx_byte_valid), 0);
    chk("R5 ovf sticky", 32'(tx_ovf_flag), 1);

    // R10: receive ring full
    for (int k = 0; k < 33; k++) push_rx(8'(k));
    chk("R10 rx full level", 32'(rx_level), 32);
    rd_word(8'h14);
    chk("R8 first word", reg_rdata, 32'h03020100);
    chk("R8 level after read", 32'(rx_level), 28);

    // R11 software reset
    pulse_sw_rst();
    chk("R11 levels", {26'b0, rx_level} | {26'b0, tx_level}, 0);
    chk("R11 flags", {30'b0, tx_ovf_flag, rx_unf_flag}, 0);
    chk("R11 rdata", reg_rdata, 0);

    // R8 partial final word, both byte orders
    push_rx(8'hAA); push_rx(8'hBB);
    rd_word(8'h14);
    chk("R8 partial low", reg_rdata, 32'h0000BBAA);
    chk("R8 partial level", 32'(rx_level), 0);
    order_ctl = 4'b0111;
    push_rx(8'hAA); push_rx(8'hBB);
    rd_word(8'h14);
    chk("R7 R8 partial swapped", reg_rdata, 32'hAABB0000);

    // R9 empty read
    rd_word(8'h14);
    chk("R9 empty rdata", reg_rdata, 0);
    chk("R9 unf set", 32'(rx_unf_flag), 1);
    wr_word(8'h10, 32'h0);
    chk("R9 unf sticky", 32'(rx_unf_flag), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule